// File: doc/BRIEF.md
# Two-Stream Descending Run Merger

This block takes two input streams and produces one output stream. Each input stream is a series of runs. A run is a group of words already sorted from largest to smallest, and its last word carries an end-of-run flag. The block pairs the current run from input A with the current run from input B and emits one merged run, also ordered largest first. It is one stage of a systolic merge-sort pipeline: first-word-fall-through queues feed its two inputs, and a queue takes its output.

Each word is `DATA_W` data bits with two flags above them. Bit `DATA_W` is the end-of-run flag. Bit `DATA_W+1` is the end-of-input marker, which the block carries through without acting on it.

The merge works in two phases. While both runs still have words left, the block compares the two head words and takes the larger one. Every word taken this way leaves with its end-of-run flag cleared. Once the word that closes one run has been taken, the block copies the rest of the other run unchanged, up to and including that run's end-of-run word. It then waits until both inputs have a head word before it starts the next merge.

Both inputs use valid/ready. A word transfers on a cycle where valid and ready are both high. A source must keep valid high and its word steady until the word is taken. The block back-pressures an input by holding ready low. Ready depends on that input's valid in the same cycle. The output has no back-pressure: `out_valid` pulses once per word, and the downstream queue must take every word.

The plain input `en` freezes the block. While `en` is low, both readies stay low and no word is emitted.

Top module: `run_merger`

## Requirements
- R1: After reset, `out_valid`, `a_ready` and `b_ready` are low.
- R2: In the merge phase, the head with the larger data goes out first. On equal data, the B word goes first. A word taken in cycle t appears on `out_word` with `out_valid` high in cycle t+1.
- R3: A word taken in the merge phase is emitted with bit `DATA_W` (end-of-run) cleared. All its other bits, including bit `DATA_W+1` (end-of-input), are unchanged.
- R4: Once a word with bit `DATA_W` set has been taken from one input during the merge phase, the other input's words are copied out unchanged, up to and including its next word with bit `DATA_W` set.
- R5: After a run finishes, no word is taken from either input until both `a_valid` and `b_valid` have been high. While only one side is valid, nothing is taken and nothing is emitted.
- R6: While `en` is low, `a_ready` and `b_ready` are low, `out_valid` is low in the next cycle, and the merge state is held. The merged stream is the same as it would be without the pauses.
- R7: The comparison is unsigned and uses only bits `DATA_W-1:0`. The two flag bits have no effect on which word wins.
- R8: When both inputs stay valid, a pair of runs with lengths LA and LB takes exactly LA+LB+1 cycles, with one word taken in every cycle except the first.
- R9: `a_ready` is high only while `a_valid` is high, and `b_ready` only while `b_valid` is high. The two readies are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | System enable; low freezes the block |
| a_valid | input | 1 | Input A head word present |
| a_ready | output | 1 | Input A head word taken this cycle |
| a_word | input | DATA_W+2 | Input A head word: {eoi, eos, data} |
| b_valid | input | 1 | Input B head word present |
| b_ready | output | 1 | Input B head word taken this cycle |
| b_word | input | DATA_W+2 | Input B head word: {eoi, eos, data} |
| out_valid | output | 1 | Output word written this cycle |
| out_word | output | DATA_W+2 | Merged output word |

## Verification
The riskiest overlap is a run's closing word being taken in the merge phase in the same cycle that the comparison meets a tie, or meets a loser whose flag bits are set. That single cycle must pick B on the tie, ignore the flags in the comparison, clear the end-of-run flag in the output word and switch to copying the other run. The bench provokes this with swept run pairs of constant, equal and descending values, plus fixed pairs that put flagged low words against unflagged high ones. The enable is also pulsed low on a fixed pattern while input gaps vary, so a pause can land on the closing word of a copy. Each case is judged by comparing every output word against a merged stream that the bench computes, and by checking that readies and `out_valid` stay low during and just after each pause.

// File: rtl/run_merge_pkg.sv
`timescale 1ns/1ps
package run_merge_pkg;
  typedef enum logic [2:0] {
    ST_START  = 3'd0,
    ST_WAIT_A = 3'd1,
    ST_WAIT_B = 3'd2,
    ST_BOTH   = 3'd3,
    ST_PASS_A = 3'd4,
    ST_PASS_B = 3'd5
  } merge_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } src_sel_e;
endpackage

// File: rtl/merge_cmp.sv
`timescale 1ns/1ps
module merge_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_key,
  input  logic [DATA_W-1:0] b_key,
  output logic              a_wins
);
  // strictly greater: equal keys favour B
  always_comb a_wins = (a_key > b_key);
endmodule

// File: rtl/merge_ctrl.sv
`timescale 1ns/1ps
module merge_ctrl
  import run_merge_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     a_valid,
  input  logic     b_valid,
  input  logic     a_eos,
  input  logic     b_eos,
  input  logic     a_wins,
  output logic     a_pop,
  output logic     b_pop,
  output src_sel_e sel,
  output logic     clr_eos
);
  merge_state_e st, st_nx;

  always_comb begin
    st_nx   = st;
    a_pop   = 1'b0;
    b_pop   = 1'b0;
    sel     = SRC_NONE;
    clr_eos = 1'b0;
    if (en) begin
      case (st)
        ST_START: begin
          if (a_valid && b_valid) st_nx = ST_BOTH;
          else if (a_valid)       st_nx = ST_WAIT_B;
          else if (b_valid)       st_nx = ST_WAIT_A;
        end
        ST_WAIT_A: if (a_valid) st_nx = ST_BOTH;
        ST_WAIT_B: if (b_valid) st_nx = ST_BOTH;
        ST_BOTH: begin
          if (a_valid && b_valid) begin
            clr_eos = 1'b1;
            if (a_wins) begin
              a_pop = 1'b1;
              sel   = SRC_A;
              if (a_eos) st_nx = ST_PASS_B;
            end else begin
              b_pop = 1'b1;
              sel   = SRC_B;
              if (b_eos) st_nx = ST_PASS_A;
            end
          end
        end
        ST_PASS_A: begin
          if (a_valid) begin
            a_pop = 1'b1;
            sel   = SRC_A;
            if (a_eos) st_nx = ST_START;
          end
        end
        ST_PASS_B: begin
          if (b_valid) begin
            b_pop = 1'b1;
            sel   = SRC_B;
            if (b_eos) st_nx = ST_START;
          end
        end
        default: st_nx = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_START;
    else        st <= st_nx;
  end

  AST_POP_A_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    a_pop |-> a_valid); // R9
  AST_POP_B_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    b_pop |-> b_valid); // R9
  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_pop && b_pop)); // R9
  AST_OFF_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st)); // R6
  AST_TIE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BOTH && b_pop) |-> !a_wins); // R2
  AST_START_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START || st == ST_WAIT_A || st == ST_WAIT_B) |-> !(a_pop || b_pop)); // R5
endmodule

// File: rtl/merge_out_reg.sv
`timescale 1ns/1ps
module merge_out_reg #(
  parameter int WORD_W  = 10,
  parameter int EOS_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr_eos,
  input  logic [WORD_W-1:0] word_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam logic [WORD_W-1:0] EOS_MASK = WORD_W'(1) << EOS_BIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= load;
      if (load) out_word <= clr_eos ? (word_in & ~EOS_MASK) : word_in;
    end
  end

  AST_LOAD_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !out_valid); // R2
  AST_CLEARED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clr_eos) |=> !out_word[EOS_BIT]); // R3
endmodule

// File: rtl/run_merger.sv
`timescale 1ns/1ps
module run_merger
  import run_merge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [DATA_W+1:0] a_word,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [DATA_W+1:0] b_word,
  output logic              out_valid,
  output logic [DATA_W+1:0] out_word
);
  localparam int WORD_W  = DATA_W + 2;
  localparam int EOS_BIT = DATA_W;

  logic        a_wins, clr_eos;
  src_sel_e    sel;
  logic [WORD_W-1:0] pick;

  merge_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_key (a_word[DATA_W-1:0]),
    .b_key (b_word[DATA_W-1:0]),
    .a_wins(a_wins)
  );

  merge_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .a_valid(a_valid),
    .b_valid(b_valid),
    .a_eos  (a_word[EOS_BIT]),
    .b_eos  (b_word[EOS_BIT]),
    .a_wins (a_wins),
    .a_pop  (a_ready),
    .b_pop  (b_ready),
    .sel    (sel),
    .clr_eos(clr_eos)
  );

  always_comb begin
    case (sel)
      SRC_A:   pick = a_word;
      SRC_B:   pick = b_word;
      default: pick = '0;
    endcase
  end

  merge_out_reg #(.WORD_W(WORD_W), .EOS_BIT(EOS_BIT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sel != SRC_NONE),
    .clr_eos  (clr_eos),
    .word_in  (pick),
    .out_valid(out_valid),
    .out_word (out_word)
  );

  AST_OFF_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid); // R6
  AST_OFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(a_ready || b_ready)); // R6
  AST_TAKE_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_valid && a_ready) || (b_valid && b_ready)) |=> out_valid); // R2
endmodule

// File: tb/test_run_merger.sv
`timescale 1ns/1ps
module test_run_merger;
  localparam int DW = 4;
  localparam int W  = DW + 2;

  logic clk = 1'b0;
  logic rst_n, en;
  logic a_valid, b_valid, a_ready, b_ready, out_valid;
  logic [W-1:0] a_word, b_word, out_word;

  always #10 clk = ~clk;

  run_merger #(.DATA_W(DW)) i_run_merger (
    .clk(clk), .rst_n(rst_n), .en(en),
    .a_valid(a_valid), .a_ready(a_ready), .a_word(a_word),
    .b_valid(b_valid), .b_ready(b_ready), .b_word(b_word),
    .out_valid(out_valid), .out_word(out_word)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [W-1:0] qa [0:511];
  logic [W-1:0] qb [0:511];
  logic [W-1:0] qe [0:1023];
  int na, nb, ne, exp_cyc;

  function automatic logic [W-1:0] mk(input bit eoi, input bit eos, input int d);
    mk = {eoi, eos, DW'(d)};
  endfunction

  // expected merge of runs qa[sa..sa+la-1] and qb[sb..sb+lb-1]
  task automatic merge_pair(input int sa, input int la, input int sb, input int lb);
    int ia = 0;
    int ib = 0;
    bit done = 0;
    while (!done) begin
      if (qa[sa+ia][DW-1:0] > qb[sb+ib][DW-1:0]) begin
        qe[ne] = qa[sa+ia]; qe[ne][DW] = 1'b0; ne++;
        ia++;
        if (ia == la) begin
          for (int j = ib; j < lb; j++) begin qe[ne] = qb[sb+j]; ne++; end
          done = 1;
        end
      end else begin
        qe[ne] = qb[sb+ib]; qe[ne][DW] = 1'b0; ne++;
        ib++;
        if (ib == lb) begin
          for (int j = ia; j < la; j++) begin qe[ne] = qa[sa+j]; ne++; end
          done = 1;
        end
      end
    end
    exp_cyc += 1 + la + lb;
  endtask

  task automatic add_pair(input int la, input int lb, input int abase, input int astep,
                          input int bbase, input int bstep, input bit aeoi, input bit beoi);
    int sa = na;
    int sb = nb;
    for (int i = 0; i < la; i++) begin
      qa[na] = mk(aeoi && (i == la-1), i == la-1, abase - i*astep); na++;
    end
    for (int i = 0; i < lb; i++) begin
      qb[nb] = mk(beoi && (i == lb-1), i == lb-1, bbase - i*bstep); nb++;
    end
    merge_pair(sa, la, sb, lb);
  endtask

  task automatic build(input int salt);
    na = 0; nb = 0; ne = 0; exp_cyc = 0;
    for (int la = 1; la <= 3; la++)
      for (int lb = 1; lb <= 3; lb++)
        for (int s = 0; s < 4; s++)
          add_pair(la, lb, 15 - ((s + salt) % 5), (s + la) % 3,
                   15 - ((s*3 + lb + salt) % 6), (s + lb + salt) % 3,
                   (s % 2) == 0, (s % 3) == 1);
    // R7: flagged small A word against unflagged larger B words
    add_pair(1, 2, 5, 0, 6, 0, 1'b1, 1'b0);
    // R2: tie, single-word runs
    add_pair(1, 1, 7, 0, 7, 0, 1'b0, 1'b1);
    // R7: A wins on data while B carries both flags
    add_pair(2, 1, 9, 1, 3, 0, 1'b0, 1'b1);
  endtask

  // gmode: 0 none, 1 periodic input gaps; emode: 0 always on, 1 pauses
  task automatic run_phase(input int gmode, input int emode, input int hold_b,
                           input bit check_cyc, input string tag);
    int pa = 0, pb = 0, pe = 0, cyc = 0, busy = 0;
    bit va = 0, vb = 0, prev_en = 1;
    while (pe < ne && cyc < 20000) begin
      @(negedge clk);
      if (out_valid) begin
        checks++;
        if (pe >= ne || out_word !== qe[pe]) begin
          errors++;
          $display("FAIL R2 R3 R4 R7 %s word %0d: got %h exp %h", tag, pe, out_word,
                   (pe < ne) ? qe[pe] : '0);
        end
        pe++;
      end
      if (!prev_en) begin
        checks++;
        if (out_valid !== 1'b0) begin
          errors++;
          $display("FAIL R6 %s out_valid after pause: got %b exp 0", tag, out_valid);
        end
      end
      if (cyc > 0 && cyc < hold_b) begin
        checks++;
        if (out_valid !== 1'b0 || a_ready !== 1'b0) begin
          errors++;
          $display("FAIL R5 %s one side valid: got out_valid=%b a_ready=%b exp 0 0",
                   tag, out_valid, a_ready);
        end
      end
      en = (emode == 0) ? 1'b1 : ((cyc % 7) != 3 && (cyc % 11) != 5);
      if (!va && pa < na && (gmode == 0 || (cyc % 3) != 1)) va = 1;
      if (!vb && pb < nb && cyc >= hold_b && (gmode == 0 || (cyc % 4) != 2)) vb = 1;
      a_valid = va; a_word = va ? qa[pa] : '0;
      b_valid = vb; b_word = vb ? qb[pb] : '0;
      #1;
      if (!en) begin
        checks++;
        if (a_ready !== 1'b0 || b_ready !== 1'b0) begin
          errors++;
          $display("FAIL R6 %s ready while off: got %b%b exp 00", tag, a_ready, b_ready);
        end
      end
      if ((a_ready && !a_valid) || (b_ready && !b_valid) || (a_ready && b_ready)) begin
        errors++;
        $display("FAIL R9 %s ready: got a=%b/%b b=%b/%b exp single ready with valid",
                 tag, a_ready, a_valid, b_ready, b_valid);
      end
      prev_en = en;
      if (pa < na || pb < nb) busy++;
      @(posedge clk);
      if (va && a_ready) begin va = 0; pa++; end
      if (vb && b_ready) begin vb = 0; pb++; end
      cyc++;
    end
    checks++;
    if (pe != ne || pa != na || pb != nb) begin
      errors++;
      $display("FAIL R4 %s drained: got %0d/%0d/%0d exp %0d/%0d/%0d", tag, pe, pa, pb, ne, na, nb);
    end
    if (check_cyc) begin
      checks++;
      if (busy != exp_cyc) begin
        errors++;
        $display("FAIL R8 %s cycles: got %0d exp %0d", tag, busy, exp_cyc);
      end
    end
    a_valid = 0; b_valid = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 1; a_valid = 0; b_valid = 0; a_word = '0; b_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    checks++;
    if (out_valid !== 1'b0 || a_ready !== 1'b0 || b_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got %b%b%b exp 000", out_valid, a_ready, b_ready);
    end
    build(0); run_phase(0, 0, 0, 1'b1, "R8_steady");
    build(1); run_phase(1, 0, 6, 1'b0, "R5_gaps");
    build(2); run_phase(1, 1, 0, 1'b0, "R6_pauses");
    build(3); run_phase(0, 1, 4, 1'b0, "R6_R5_mix");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule